// File: doc/BRIEF.md
# Reload Down-Counter Timer

A 24-bit periodic down-counter behind a four-word register window. Software writes a reload value, sets the enable bit, and the counter counts down on each active tick. An active tick is every core clock cycle, or each cycle that an external reference tick-enable input is high, depending on a clock-source bit. When the counter steps from 1 to 0 it has expired. On expiry it raises a sticky count flag and, if interrupts are enabled, a one-cycle interrupt pulse. On the next active tick it loads the reload value again, so the period is reload + 1 ticks.

The register window answers full-word, privileged accesses only. An access that is unprivileged or narrower than a word gets an error response and leaves every piece of state alone. Reads return data combinationally in the same cycle as the request. Side effects (register updates and flag clearing) take place at the clock edge that ends the access.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the control bits, count flag, counter and reload value are all zero, and the interrupt output is low.
- R2: The registers are at these byte offsets: control/status at 0x0, reload at 0x4, current count at 0x8, calibration at 0xC. The calibration word always reads 10000. Any other offset reads zero, and writes to other offsets change nothing.
- R3: In control/status, bit 0 is enable, bit 1 is interrupt enable, bit 2 is clock source (1 = every core cycle, 0 = the reference tick input) and bit 16 is the count flag. A write changes only bits 2:0.
- R4: A read of control/status returns the count flag as it stands, then clears the flag at the end of that read.
- R5: A write to the reload register keeps only data bits 23:0, and bits 31:24 read back as zero.
- R6: A write of any data to the current-count register sets the counter to zero and clears the count flag. The next active tick then loads the reload value.
- R7: On an active tick the counter decrements. Only a step from 1 to 0 counts as an expiry, and the tick after an expiry loads the reload value.
- R8: An expiry sets the count flag. If the interrupt-enable bit is set, the expiry also drives the interrupt output high for exactly one cycle; otherwise the output stays low.
- R9: With clock source 0 the counter moves only on cycles where the reference tick input is high. With clock source 1 it moves every cycle.
- R10: An expiry while the reload value is zero stops counting, including after a later reload write, while the enable bit stays set. Writing enable from 0 to 1 restarts counting.
- R11: A read or write with the privilege input low returns an error with read data zero. It changes no register and does not clear the count flag.
- R12: An access whose size input is not 2'b10 (word) returns an error and has no side effects.
- R13: Clearing enable holds the counter at its value. Setting it again resumes counting from that value on the next active tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Reference tick enable, used when clock source is 0 |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | 1 = privileged access |
| bus_size | input | 2 | Access size, 2'b10 = 32-bit word |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Error response, valid in the request cycle |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Read data and the error response are combinational, so the bench drives each request just after a falling edge and samples a quarter period later, before the rising edge that commits the access. Register writes, counter steps and flag changes land on that rising edge and can be seen from the next request onward. The interrupt pulse is high in the cycle that follows the expiring tick's edge. The bench therefore applies each reference tick for exactly one rising edge and reads the interrupt output at the next falling edge. In core-clock mode, back-to-back reads of the count are one cycle apart and must differ by exactly one.

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
  parameter int          CNT_W     = 24,
  parameter int          ADDR_W    = 8,
  parameter int          FLAG_POS  = 16,
  parameter logic [31:0] CAL_VALUE = 32'd10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_priv,
  input  logic [1:0]        bus_size,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              irq_pulse
);
  localparam logic [1:0]        SIZE_WORD = 2'b10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_LOAD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CUR   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_CAL   = ADDR_W'(12);
  localparam int                PAD_W     = 32 - CNT_W;

  logic [2:0]       ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             halted_q;
  logic             irq_q;

  logic access, wr_ok, rd_ok;
  logic wr_ctrl, wr_load, wr_cur, rd_ctrl;
  logic tick_en, expire;
  logic unused_wdata;

  assign access  = bus_wr | bus_rd;
  assign bus_err = access & (~bus_priv | (bus_size != SIZE_WORD));
  assign wr_ok   = bus_wr & ~bus_err;
  assign rd_ok   = bus_rd & ~bus_err;

  assign wr_ctrl = wr_ok & (bus_addr == OFF_CTRL);
  assign wr_load = wr_ok & (bus_addr == OFF_LOAD);
  assign wr_cur  = wr_ok & (bus_addr == OFF_CUR);
  assign rd_ctrl = rd_ok & (bus_addr == OFF_CTRL);

  assign tick_en = ctrl_q[0] & ~halted_q & (ctrl_q[2] | ref_tick_i);
  assign expire  = tick_en & ~wr_cur & (cnt_q == CNT_W'(1));
  assign unused_wdata = ^bus_wdata[31:CNT_W];
  assign irq_pulse = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_load) begin
      reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cur) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
    end else if (wr_ctrl && bus_wdata[0] && !ctrl_q[0]) begin
      halted_q <= 1'b0;
    end else if (expire && reload_q == '0) begin
      halted_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire & ctrl_q[1];
      if (wr_cur)       flag_q <= 1'b0;
      else if (expire)  flag_q <= 1'b1;
      else if (rd_ctrl) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (bus_addr)
        OFF_CTRL: begin
          bus_rdata[2:0]      = ctrl_q;
          bus_rdata[FLAG_POS] = flag_q;
        end
        OFF_LOAD: bus_rdata = {{PAD_W{1'b0}}, reload_q};
        OFF_CUR:  bus_rdata = {{PAD_W{1'b0}}, cnt_q};
        OFF_CAL:  bus_rdata = CAL_VALUE;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/reload_down_timer_chk.sv
module reload_down_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic              bus_priv,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              irq_pulse,
  input logic [2:0]        ctrl_q,
  input logic              flag_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag_q);
  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (cnt_q == '0) && $past(ctrl_q[1]));
  // R11
  unpriv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_priv) |-> bus_err && bus_rdata == '0);
  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> $stable(reload_q) && $stable(ctrl_q));
  // R5
  reload_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_err && bus_addr == ADDR_W'(4)) |-> bus_rdata[31:CNT_W] == '0);
  // R2
  cal_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_err && bus_addr == ADDR_W'(12)) |-> bus_rdata == 32'd10000);
  // R6
  cur_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_err && bus_addr == ADDR_W'(8)) |=> cnt_q == '0 && !flag_q);
  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_err && bus_addr == ADDR_W'(0)) |=> ctrl_q == $past(bus_wdata[2:0]));
endmodule

bind reload_down_timer reload_down_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .irq_pulse(irq_pulse), .ctrl_q(ctrl_q), .flag_q(flag_q), .reload_q(reload_q), .cnt_q(cnt_q)
);

// File: tb/test_reload_down_timer.sv
module test_reload_down_timer;
  logic        clk = 0, rst_n = 0, ref_tick_i = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, bus_priv = 0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_rdata;
  logic        bus_err, irq_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  reload_down_timer i_reload_down_timer (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_pulse(irq_pulse));

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        priv;
    logic [1:0]  size;
    logic [31:0] exp;
    logic        exp_err;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 1'b1, 2'b10, 32'h0,         1'b0, "R5"},
    '{1'b0, 8'h04, 32'h0,         1'b1, 2'b10, 32'h00FF_FFFF, 1'b0, "R5"},
    '{1'b0, 8'h0C, 32'h0,         1'b1, 2'b10, 32'd10000,     1'b0, "R2"},
    '{1'b0, 8'h10, 32'h0,         1'b1, 2'b10, 32'h0,         1'b0, "R2"},
    '{1'b1, 8'h10, 32'h1234_5678, 1'b1, 2'b10, 32'h0,         1'b0, "R2"},
    '{1'b0, 8'h04, 32'h0,         1'b1, 2'b10, 32'h00FF_FFFF, 1'b0, "R2"},
    '{1'b1, 8'h00, 32'hFFFF_FFFA, 1'b1, 2'b10, 32'h0,         1'b0, "R3"},
    '{1'b0, 8'h00, 32'h0,         1'b1, 2'b10, 32'h0000_0002, 1'b0, "R3"},
    '{1'b1, 8'h04, 32'h5,         1'b0, 2'b10, 32'h0,         1'b1, "R11"},
    '{1'b0, 8'h04, 32'h0,         1'b1, 2'b10, 32'h00FF_FFFF, 1'b0, "R11"},
    '{1'b1, 8'h04, 32'h7,         1'b1, 2'b01, 32'h0,         1'b1, "R12"},
    '{1'b0, 8'h04, 32'h0,         1'b1, 2'b00, 32'h0,         1'b1, "R12"},
    '{1'b0, 8'h04, 32'h0,         1'b1, 2'b10, 32'h00FF_FFFF, 1'b0, "R12"},
    '{1'b0, 8'h00, 32'h0,         1'b0, 2'b10, 32'h0,         1'b1, "R11"},
    '{1'b0, 8'h08, 32'h0,         1'b1, 2'b10, 32'h0,         1'b0, "R1"}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                        input logic priv, input logic [1:0] size,
                        output logic [31:0] rdata, output logic err);
    bus_wr = wr; bus_rd = ~wr; bus_addr = addr; bus_wdata = data;
    bus_priv = priv; bus_size = size;
    #1;
    rdata = bus_rdata; err = bus_err;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    logic [31:0] d; logic e;
    access(1'b1, addr, data, 1'b1, 2'b10, d, e);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] d; logic e;
    access(1'b0, addr, 32'h0, 1'b1, 2'b10, d, e);
    chk(tag, d, exp);
  endtask

  task automatic tick(input string tag, input logic exp_irq);
    ref_tick_i = 1;
    @(posedge clk);
    @(negedge clk);
    ref_tick_i = 0;
    chk(tag, {31'b0, irq_pulse}, {31'b0, exp_irq});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang exp finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2; logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {31'b0, irq_pulse}, 32'h0);
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", 8'h04, 32'h0);
    rd_chk("R1", 8'h08, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].priv, VEC[i].size, d, e);
      chk($sformatf("%s err", VEC[i].tag), {31'b0, e}, {31'b0, VEC[i].exp_err});
      if (!VEC[i].wr) chk($sformatf("%s data", VEC[i].tag), d, VEC[i].exp);
    end

    // R6 R7 R8: reference-tick mode, reload 2
    wr(8'h04, 32'd2);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h3);
    tick("R6", 1'b0);
    rd_chk("R6", 8'h08, 32'd2);
    tick("R7", 1'b0);
    rd_chk("R7", 8'h08, 32'd1);
    tick("R8", 1'b1);
    rd_chk("R7", 8'h08, 32'd0);
    rd_chk("R4", 8'h00, 32'h0001_0003);
    rd_chk("R4", 8'h00, 32'h0000_0003);
    tick("R7", 1'b0);
    rd_chk("R7", 8'h08, 32'd2);
    repeat (5) @(negedge clk);
    rd_chk("R9", 8'h08, 32'd2);

    // R13 hold and resume
    wr(8'h00, 32'h2);
    tick("R13", 1'b0);
    rd_chk("R13", 8'h08, 32'd2);
    wr(8'h00, 32'h3);
    tick("R13", 1'b0);
    rd_chk("R13", 8'h08, 32'd1);

    // R6 write to current clears counter and flag
    tick("R8", 1'b1);
    wr(8'h08, 32'h0000_0ABC);
    rd_chk("R6", 8'h00, 32'h0000_0003);
    rd_chk("R6", 8'h08, 32'd0);
    tick("R6", 1'b0);
    rd_chk("R6", 8'h08, 32'd2);

    // R11 R12 rejected reads keep the flag
    tick("R7", 1'b0);
    tick("R8", 1'b1);
    access(1'b0, 8'h00, 32'h0, 1'b0, 2'b10, d, e);
    chk("R11 err", {31'b0, e}, 32'h1);
    chk("R11 data", d, 32'h0);
    access(1'b0, 8'h00, 32'h0, 1'b1, 2'b01, d, e);
    chk("R12 err", {31'b0, e}, 32'h1);
    rd_chk("R11", 8'h00, 32'h0001_0003);

    // R10 expiry with zero reload stops counting
    wr(8'h04, 32'd1);
    wr(8'h08, 32'h0);
    tick("R10", 1'b0);
    rd_chk("R10", 8'h08, 32'd1);
    wr(8'h04, 32'd0);
    tick("R10", 1'b1);
    rd_chk("R10", 8'h00, 32'h0001_0003);
    wr(8'h04, 32'd5);
    tick("R10", 1'b0);
    tick("R10", 1'b0);
    rd_chk("R10", 8'h08, 32'd0);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h3);
    tick("R13", 1'b0);
    rd_chk("R13", 8'h08, 32'd5);

    // R9 core clock source, R8 no interrupt with tickint clear
    wr(8'h00, 32'h5);
    access(1'b0, 8'h08, 32'h0, 1'b1, 2'b10, d, e);
    access(1'b0, 8'h08, 32'h0, 1'b1, 2'b10, d2, e);
    chk("R9", d, 32'd5);
    chk("R9", d2, 32'd4);
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (irq_pulse) seen++;
      end
      chk("R8 no irq", seen, 0);
    end
    rd_chk("R8", 8'h00, 32'h0001_0005);

    // R1 reset mid-run
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {31'b0, irq_pulse}, 32'h0);
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", 8'h04, 32'h0);
    rd_chk("R1", 8'h08, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule